// File: doc/BRIEF.md
# Compare and Trap Condition Unit

This block judges how two operands relate and turns that judgement into either a three-bit condition field for compare instructions or a single trap request for trap instructions. From the two operands it forms one five-bit relation vector. A compare takes three bits of that vector. A trap masks the vector with a five-bit condition mask and requests a trap when any masked bit remains.

The operands may be compared at full doubleword width or in word mode. In word mode only the low half of each operand takes part. That half is sign-extended for the signed relations and zero-extended for the unsigned ones. Both outputs are registered once, so a result appears on the clock edge that follows the inputs. Writing the condition register and raising the program interrupt are left to the surrounding pipeline.

Top module: `cmp_trap_unit`

## Requirements
- R1: While `rst_n` is low, `crf` is 3'b000 and `trap_req` is 0.
- R2: Outputs are registered once. Inputs presented before a rising edge appear on `crf` and `trap_req` after that edge.
- R3: With `is_signed`=1, `crf` is {lt, gt, eq} (bit 2 = less, bit 1 = greater, bit 0 = equal) for `opa` compared to `opb` as two's-complement numbers.
- R4: With `is_signed`=0, `crf` uses the same bit positions and compares `opa` to `opb` as unsigned numbers.
- R5: With `is_word`=1, only bits [31:0] of each operand are used, and the upper 32 bits have no effect on either output. Bits [31:0] are sign-extended for signed relations and zero-extended for unsigned ones.
- R6: In every cycle after reset has been released, exactly one bit of `crf` is set.
- R7: The relation vector is {slt, sgt, eq, ult, ugt} with bit 4 first. When `op_trap`=1, `trap_req` is 1 exactly when (vector & `trap_mask`) is nonzero. Word mode applies as in R5.
- R8: When `op_trap`=0, `trap_req` is 0 whatever `trap_mask` holds.
- R9: With `op_trap`=1, a `trap_mask` of 5'b00000 never requests a trap, and 5'b11111 always does.
- R10: `crf` is formed in both operation types. During a trap operation it still reflects the compare selection of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| is_word | input | 1 | 1 selects a 32-bit comparison of the low halves |
| is_signed | input | 1 | For compare: 1 selects the signed less and greater relations |
| op_trap | input | 1 | 1 = trap operation, 0 = compare operation |
| trap_mask | input | 5 | Trap condition mask, aligned with the relation vector |
| crf | output | 3 | Registered condition field {lt, gt, eq} |
| trap_req | output | 1 | Registered trap request |

## Verification
The compare selection and the trap decision are both derived from the same relation vector in the same cycle. During a trap operation `crf` keeps being formed, so both outputs carry meaning together. The bench issues trap operations with random and directed operands and checks `crf` and `trap_req` on the same sample against separately computed models. Inputs where the signed and unsigned orders disagree, such as an operand whose sign bit is set, confirm that the mask picks the intended relation while the compare field follows `is_signed`.

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_word,
  input  logic              is_signed,
  input  logic              op_trap,
  input  logic [MASK_W-1:0] trap_mask,
  output logic [2:0]        crf,
  output logic              trap_req
);
  localparam int EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] sa, sb, ua, ub;
  logic [MASK_W-1:0] rel;
  logic [2:0]        crf_d;
  logic              trap_d;

  assign sa = is_word ? {{EXT_W{opa[WORD_W-1]}}, opa[WORD_W-1:0]} : opa;
  assign sb = is_word ? {{EXT_W{opb[WORD_W-1]}}, opb[WORD_W-1:0]} : opb;
  assign ua = is_word ? {{EXT_W{1'b0}}, opa[WORD_W-1:0]} : opa;
  assign ub = is_word ? {{EXT_W{1'b0}}, opb[WORD_W-1:0]} : opb;

  assign rel = {$signed(sa) < $signed(sb), $signed(sa) > $signed(sb),
                ua == ub, ua < ub, ua > ub};

  assign crf_d  = is_signed ? {rel[4], rel[3], rel[2]} : {rel[1], rel[0], rel[2]};
  assign trap_d = op_trap & (|(rel & trap_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crf      <= 3'b000;
      trap_req <= 1'b0;
    end else begin
      crf      <= crf_d;
      trap_req <= trap_d;
    end
  end
endmodule

module cmp_trap_unit_chk #(
  parameter int DATA_W = 64,
  parameter int MASK_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              is_word,
  input logic              is_signed,
  input logic              op_trap,
  input logic [MASK_W-1:0] trap_mask,
  input logic [2:0]        crf,
  input logic              trap_req
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (crf == 3'b000 && !trap_req));

  p_one_hot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(crf) == 1));

  p_cmp_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_trap |=> !trap_req);

  p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_mask == '0) |=> !trap_req);

  p_mask_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_trap && trap_mask == '1) |=> trap_req);

  p_equal_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opa == opb) |=> (crf == 3'b001));

  p_upper_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_word && opa[31:0] == opb[31:0]) |=> (crf == 3'b001));
endmodule

bind cmp_trap_unit cmp_trap_unit_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .is_word(is_word),
  .is_signed(is_signed), .op_trap(op_trap), .trap_mask(trap_mask),
  .crf(crf), .trap_req(trap_req)
);

// File: tb/cmp_trap_unit_test.sv
module cmp_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        is_word = 1'b0, is_signed = 1'b0, op_trap = 1'b0;
  logic [4:0]  trap_mask = '0;
  logic [2:0]  crf;
  logic        trap_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .is_word(is_word),
    .is_signed(is_signed), .op_trap(op_trap), .trap_mask(trap_mask),
    .crf(crf), .trap_req(trap_req)
  );

  function automatic logic [4:0] rel_model(logic [63:0] a, logic [63:0] b, logic w);
    logic slt, sgt, eq, ult, ugt;
    if (w) begin
      slt = $signed(a[31:0]) < $signed(b[31:0]);
      sgt = $signed(a[31:0]) > $signed(b[31:0]);
      ult = a[31:0] < b[31:0];
      ugt = a[31:0] > b[31:0];
      eq  = a[31:0] == b[31:0];
    end else begin
      slt = $signed(a) < $signed(b);
      sgt = $signed(a) > $signed(b);
      ult = a < b;
      ugt = a > b;
      eq  = a == b;
    end
    return {slt, sgt, eq, ult, ugt};
  endfunction

  function automatic logic [2:0] crf_model(logic [4:0] r, logic s);
    return s ? {r[4], r[3], r[2]} : {r[1], r[0], r[2]};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic w, logic s,
                       logic t, logic [4:0] m, string req);
    logic [4:0] r;
    @(negedge clk);
    opa = a; opb = b; is_word = w; is_signed = s; op_trap = t; trap_mask = m;
    r = rel_model(a, b, w);
    @(posedge clk);
    #1;
    check({req, " crf"}, {29'd0, crf}, {29'd0, crf_model(r, s)});
    check({req, " trap"}, {31'd0, trap_req}, {31'd0, t & (|(r & m))});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'h5eed1234));
    opa = 64'hffff; opb = 64'h1; op_trap = 1'b1; trap_mask = 5'h1f;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset crf", {29'd0, crf}, 32'd0);
    check("R1 reset trap", {31'd0, trap_req}, 32'd0);
    @(negedge clk);
    op_trap = 1'b0; opa = 64'd5; opb = 64'd9; is_signed = 1'b1;
    rst_n = 1'b1;
    #1;
    check("R2 no change before edge", {29'd0, crf}, 32'd0);
    @(posedge clk);
    #1;
    check("R2 registered after edge", {29'd0, crf}, 32'h4);

    apply(64'hffff_ffff_ffff_ffff, 64'd1, 0, 1, 0, 5'h00, "R3 signed neg<pos");
    apply(64'hffff_ffff_ffff_ffff, 64'd1, 0, 0, 0, 5'h00, "R4 unsigned big>1");
    apply(64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 0, 1, 0, 5'h1f, "R8 cmp mask ignored");
    apply(64'h1234_0000_8000_0000, 64'hdead_beef_0000_0001, 1, 1, 0, 5'h00, "R5 word signed");
    apply(64'h1234_0000_8000_0000, 64'hdead_beef_0000_0001, 1, 0, 0, 5'h00, "R5 word unsigned");
    apply(64'h0000_0001_0000_0042, 64'hffff_0000_0000_0042, 1, 1, 0, 5'h00, "R5 upper ignored eq");
    apply(64'h0000_0001_0000_0042, 64'hffff_0000_0000_0042, 1, 0, 1, 5'h04, "R5 R7 word trap eq");
    apply(64'hffff_ffff_ffff_fff0, 64'd3, 0, 0, 1, 5'h10, "R7 R10 trap slt");
    apply(64'hffff_ffff_ffff_fff0, 64'd3, 0, 0, 1, 5'h02, "R7 trap ult miss");
    apply(64'd7, 64'd3, 0, 1, 1, 5'h00, "R9 mask zero");
    apply(64'd7, 64'd7, 0, 1, 1, 5'h1f, "R9 mask full eq");
    apply(64'd2, 64'd7, 1, 0, 1, 5'h1f, "R9 mask full lt");

    for (int i = 0; i < 2000; i++) begin
      a = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b = a ^ (64'd1 << ($urandom % 64));
        default: b = {$urandom, $urandom};
      endcase
      apply(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom),
            "R3 R4 R6 R7 R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule